// File: doc/BRIEF.md
# Barrel Multithreaded Issue Scheduler

This block sits at the front of a deep, interleaved pipeline and, on every clock, picks one hardware thread context whose next wide instruction may enter. Because a context may not come back into the pipeline until its previous instruction has moved far enough down it, many contexts take turns. Their memory latency is hidden behind the work of the others, and moving from one context to another costs no cycle, whichever job each context belongs to.

Each context holds a valid flag, a job (protection domain) number, a countdown that enforces the minimum re-issue distance, and a lookahead budget that bounds how far it may run ahead of its own outstanding memory references. New contexts come from an external launch request or from a spawn operation carried by an issued instruction. A quit operation releases the context. Memory completions name the context they belong to. The instruction source answers the chosen context in the same cycle with three things: a memory flag, a lookahead value and an operation kind. Each answer counts as one issue, however many operations the wide word carries.

Top module: `barrel_issue_sched`

## Requirements
- R1: After reset no context is valid, and iss_vld, iss_tid and iss_dom are all zero.
- R2: A launch request (launch_vld with launch_dom) takes the lowest-numbered free context and gives it launch_dom. The context is eligible in the cycle after the request.
- R3: A context issues at most once in any 20 consecutive cycles (SPACING=20). It is never chosen in two adjacent cycles. A context that is ready on its own issues exactly every 20 cycles.
- R4: A rotating pointer rests one past the last issued context. Among eligible contexts, the first one at or after the pointer wins, wrapping past the highest index.
- R5: An issue with ins_mem=1 and ins_la=N lets the context issue N more instructions before it stalls. A nested memory issue lowers the remaining budget to the smaller of what is left and its own N. A context stalled this way issues again in the cycle after its last outstanding reference completes.
- R6: A completion (cmp_vld with cmp_tid) has no effect when it names an invalid context or a context with no outstanding reference.
- R7: An issue with ins_op=2'b10 (quit) releases the context after that issue. The context never issues again, and its number can be reused by the next allocation.
- R8: An issue with ins_op=2'b01 (spawn) creates a context at the lowest free number. The new context has the parent's domain and is eligible in the next cycle. The spawn is ignored when no context is free.
- R9: When a spawn and a launch fall in the same cycle, the spawn takes the lowest free context and the launch takes the next free one.
- R10: In a cycle with no eligible context, iss_vld is low and iss_tid and iss_dom are zero.
- R11: iss_dom carries the domain of the chosen context. Contexts of different domains can issue in adjacent cycles with no idle cycle between them.
- R12: A launch made while every context is valid is ignored and leaves all existing contexts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_vld | input | 1 | Request to start a new context |
| launch_dom | input | DOM_W | Domain of the context being launched |
| cmp_vld | input | 1 | A memory reference has completed |
| cmp_tid | input | TID_W | Context that owns the completed reference |
| ins_mem | input | 1 | Chosen instruction carries a memory reference |
| ins_la | input | LA_W | Lookahead value of that memory reference |
| ins_op | input | 2 | Operation kind: 00 plain, 01 spawn, 10 quit, 11 plain |
| iss_vld | output | 1 | Issue strobe |
| iss_tid | output | TID_W | Context chosen this cycle |
| iss_dom | output | DOM_W | Domain of the chosen context |

## Verification
All per-context state is held in registers, and the choice is made combinationally from that state. A launch or spawn therefore shows up as an issue one cycle after the request. A completion unblocks its context one cycle after it is presented. A context that issued in cycle c is next seen no earlier than cycle c+20. The bench drives every input just after a falling edge and holds it for one cycle. It then compares the complete triple {iss_vld, iss_tid, iss_dom} at each following falling edge, cycle by cycle, against a timeline computed from these delays. Bubble cycles are checked as strictly as issue cycles.

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched #(
  parameter int NTHR    = 16,
  parameter int SPACING = 20,
  parameter int DOM_W   = 4,
  parameter int LA_W    = 3,
  parameter int PEND_W  = 3,
  localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CNT_W  = $clog2(SPACING)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_vld,
  input  logic [DOM_W-1:0] launch_dom,
  input  logic             cmp_vld,
  input  logic [TID_W-1:0] cmp_tid,
  input  logic             ins_mem,
  input  logic [LA_W-1:0]  ins_la,
  input  logic [1:0]       ins_op,
  output logic             iss_vld,
  output logic [TID_W-1:0] iss_tid,
  output logic [DOM_W-1:0] iss_dom
);

  localparam logic [1:0] OP_SPAWN = 2'b01;
  localparam logic [1:0] OP_QUIT  = 2'b10;

  logic [NTHR-1:0]   valid_q;
  logic [NTHR-1:0]   elig;
  logic [DOM_W-1:0]  dom_q  [NTHR];
  logic [CNT_W-1:0]  cnt_q  [NTHR];
  logic [PEND_W-1:0] pend_q [NTHR];
  logic [LA_W-1:0]   bud_q  [NTHR];
  logic [TID_W-1:0]  ptr_q;

  logic             sel_found;
  logic [TID_W-1:0] sel_tid;
  logic             f1_ok, f2_ok;
  logic [TID_W-1:0] f1, f2;

  always_comb begin
    int idx;
    sel_found = 1'b0;
    sel_tid   = '0;
    for (int k = 0; k < NTHR; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= NTHR) idx = idx - NTHR;
      if (!sel_found && elig[idx]) begin
        sel_found = 1'b1;
        sel_tid   = TID_W'(idx);
      end
    end
  end

  always_comb begin
    f1_ok = 1'b0; f1 = '0;
    f2_ok = 1'b0; f2 = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (!valid_q[i]) begin
        if (!f1_ok) begin
          f1_ok = 1'b1; f1 = TID_W'(i);
        end else if (!f2_ok) begin
          f2_ok = 1'b1; f2 = TID_W'(i);
        end
      end
    end
  end

  assign iss_vld = sel_found;
  assign iss_tid = sel_found ? sel_tid : '0;
  assign iss_dom = sel_found ? dom_q[sel_tid] : '0;

  wire              do_spawn   = sel_found && (ins_op == OP_SPAWN) && f1_ok;
  wire              do_quit    = sel_found && (ins_op == OP_QUIT);
  wire              launch_ok  = launch_vld && (do_spawn ? f2_ok : f1_ok);
  wire [TID_W-1:0]  launch_tid = do_spawn ? f2 : f1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (sel_found)
      ptr_q <= (sel_tid == TID_W'(NTHR - 1)) ? '0 : sel_tid + TID_W'(1);
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_ctx
    wire hit     = sel_found && (sel_tid == TID_W'(t));
    wire mk_sp   = do_spawn && (f1 == TID_W'(t));
    wire mk_ln   = launch_ok && (launch_tid == TID_W'(t));
    wire cmp_hit = cmp_vld && (cmp_tid == TID_W'(t)) && valid_q[t] && (pend_q[t] != '0);
    wire mem_hit = hit && ins_mem;
    wire [LA_W-1:0] bud_dec = bud_q[t] - LA_W'(1);

    assign elig[t] = valid_q[t] && (cnt_q[t] == '0) &&
                     ((pend_q[t] == '0) || (bud_q[t] != '0)) &&
                     (pend_q[t] != '1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[t] <= 1'b0;
        dom_q[t]   <= '0;
        cnt_q[t]   <= '0;
        pend_q[t]  <= '0;
        bud_q[t]   <= '0;
      end else if (mk_sp || mk_ln) begin
        valid_q[t] <= 1'b1;
        dom_q[t]   <= mk_sp ? iss_dom : launch_dom;
        cnt_q[t]   <= '0;
        pend_q[t]  <= '0;
        bud_q[t]   <= '0;
      end else if (hit && do_quit) begin
        valid_q[t] <= 1'b0;
        cnt_q[t]   <= '0;
        pend_q[t]  <= '0;
        bud_q[t]   <= '0;
      end else begin
        if (hit) cnt_q[t] <= CNT_W'(SPACING - 1);
        else if (cnt_q[t] != '0) cnt_q[t] <= cnt_q[t] - CNT_W'(1);

        case ({mem_hit, cmp_hit})
          2'b10:   pend_q[t] <= pend_q[t] + PEND_W'(1);
          2'b01:   pend_q[t] <= pend_q[t] - PEND_W'(1);
          default: pend_q[t] <= pend_q[t];
        endcase

        if (hit) begin
          if (ins_mem)
            bud_q[t] <= ((pend_q[t] != '0) && (bud_dec < ins_la)) ? bud_dec : ins_la;
          else if (pend_q[t] != '0)
            bud_q[t] <= bud_dec;
        end
      end
    end
  end

endmodule

// File: rtl/barrel_issue_sched_chk.sv
module barrel_issue_sched_chk #(
  parameter int NTHR    = 16,
  parameter int SPACING = 20,
  parameter int DOM_W   = 4,
  localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int GAP_W  = $clog2(SPACING)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_vld,
  input logic [TID_W-1:0] iss_tid,
  input logic [DOM_W-1:0] iss_dom,
  input logic [1:0]       ins_op
);

  for (genvar t = 0; t < NTHR; t++) begin : g_gap
    logic [GAP_W-1:0] age;
    logic             seen;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age  <= '0;
        seen <= 1'b0;
      end else if (iss_vld && iss_tid == TID_W'(t)) begin
        age  <= '0;
        seen <= (ins_op != 2'b10);
      end else if (age != GAP_W'(SPACING - 1)) begin
        age <= age + GAP_W'(1);
      end
    end

    assert_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld && iss_tid == TID_W'(t) && seen) |-> (age == GAP_W'(SPACING - 1)));
  end

  assert_no_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && $past(iss_vld)) |-> (iss_tid != $past(iss_tid)));

  assert_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_vld |-> (iss_tid == '0 && iss_dom == '0));

  assert_quit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && ins_op == 2'b10) |=> (!iss_vld || iss_tid != $past(iss_tid)));

  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !iss_vld);

endmodule

bind barrel_issue_sched barrel_issue_sched_chk #(
  .NTHR(NTHR), .SPACING(SPACING), .DOM_W(DOM_W)
) i_chk (.*);

// File: tb/test_barrel_issue_sched.sv
module test_barrel_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 16;
  localparam int TID_W = 4;
  localparam int DOM_W = 4;
  localparam int LA_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             launch_vld = 1'b0;
  logic [DOM_W-1:0] launch_dom = '0;
  logic             cmp_vld = 1'b0;
  logic [TID_W-1:0] cmp_tid = '0;
  logic             ins_mem = 1'b0;
  logic [LA_W-1:0]  ins_la = '0;
  logic [1:0]       ins_op = 2'b00;
  logic             iss_vld;
  logic [TID_W-1:0] iss_tid;
  logic [DOM_W-1:0] iss_dom;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  barrel_issue_sched #(.NTHR(NTHR)) i_barrel_issue_sched (
    .clk(clk), .rst_n(rst_n), .launch_vld(launch_vld), .launch_dom(launch_dom),
    .cmp_vld(cmp_vld), .cmp_tid(cmp_tid), .ins_mem(ins_mem), .ins_la(ins_la),
    .ins_op(ins_op), .iss_vld(iss_vld), .iss_tid(iss_tid), .iss_dom(iss_dom)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic nxt();
    @(negedge clk);
    launch_vld = 1'b0; cmp_vld = 1'b0; ins_mem = 1'b0; ins_la = '0; ins_op = 2'b00;
  endtask

  task automatic see(input string req, input bit v, input int tid, input int dom);
    logic [8:0] act, exp;
    act = {iss_vld, iss_tid, iss_dom};
    exp = v ? {1'b1, TID_W'(tid), DOM_W'(dom)} : 9'd0;
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t act={vld,tid,dom}=%h exp=%h", req, $time, act, exp);
    end
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      nxt();
      see(req, 1'b0, 0, 0);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    repeat (3) nxt();
    rst_n = 1'b1;
  endtask

  task automatic launch(input int dom);
    launch_vld = 1'b1;
    launch_dom = DOM_W'(dom);
  endtask

  task automatic t_reset();
    reset_dut();
    see("R1 reset state", 1'b0, 0, 0);
    idle("R1 idle after reset", 5);
  endtask

  task automatic t_single();
    reset_dut();
    launch(5);
    nxt();
    see("R2 launch visible next cycle", 1'b1, 0, 5);
    for (int k = 1; k <= 60; k++) begin
      nxt();
      see("R3 lone context every 20 cycles", (k % 20) == 0, 0, 5);
    end
  endtask

  task automatic t_rotate();
    reset_dut();
    launch(1);
    nxt(); see("R2 first launch", 1'b1, 0, 1);
    ins_mem = 1'b1; ins_la = 3'd0; launch(2);
    nxt(); see("R11 adjacent issue other domain", 1'b1, 1, 2);
    launch(3);
    nxt(); see("R11 adjacent issue third domain", 1'b1, 2, 3);
    idle("R5 ctx0 stalled, R10 bubble", 18);
    nxt(); see("R3 ctx1 after 20", 1'b1, 1, 2);
    cmp_vld = 1'b1; cmp_tid = 4'd0;
    nxt(); see("R4 pointer favours ctx2 over ctx0", 1'b1, 2, 3);
    nxt(); see("R4 ctx0 next in rotation", 1'b1, 0, 1);
    idle("R10 bubble", 17);
    nxt(); see("R4 rotation ctx1", 1'b1, 1, 2);
    nxt(); see("R4 rotation ctx2", 1'b1, 2, 3);
    nxt(); see("R4 rotation ctx0", 1'b1, 0, 1);
  endtask

  task automatic t_lookahead();
    reset_dut();
    launch(6);
    nxt(); see("R5 mem issue la=2", 1'b1, 0, 6);
    ins_mem = 1'b1; ins_la = 3'd2;
    idle("R5 spacing", 19);
    nxt(); see("R5 first under budget", 1'b1, 0, 6);
    idle("R5 spacing", 19);
    nxt(); see("R5 second under budget", 1'b1, 0, 6);
    idle("R5 stall on third", 29);
    cmp_vld = 1'b1; cmp_tid = 4'd0;
    nxt(); see("R5 resume after completion", 1'b1, 0, 6);
    ins_mem = 1'b1; ins_la = 3'd3;
    idle("R5 spacing", 19);
    nxt(); see("R5 nested mem la=1", 1'b1, 0, 6);
    ins_mem = 1'b1; ins_la = 3'd1;
    idle("R5 spacing", 19);
    nxt(); see("R5 min budget one more", 1'b1, 0, 6);
    idle("R5 stall two pending", 24);
    cmp_vld = 1'b1; cmp_tid = 4'd0;
    idle("R5 still stalled one pending", 5);
    cmp_vld = 1'b1; cmp_tid = 4'd0;
    nxt(); see("R5 resume after last completion", 1'b1, 0, 6);
  endtask

  task automatic t_quit();
    reset_dut();
    launch(2);
    nxt(); see("R7 ctx0 before quit", 1'b1, 0, 2);
    ins_op = 2'b10; launch(3);
    nxt(); see("R2 launch while ctx0 quits", 1'b1, 1, 3);
    ins_mem = 1'b1; ins_la = 3'd0; cmp_vld = 1'b1; cmp_tid = 4'd0;
    nxt(); see("R6 completion to quit ctx ignored", 1'b0, 0, 0);
    cmp_vld = 1'b1; cmp_tid = 4'd5;
    idle("R7 quit ctx silent, R6 ctx1 still stalled", 27);
    launch(9);
    nxt(); see("R7 freed number reused", 1'b1, 0, 9);
    cmp_vld = 1'b1; cmp_tid = 4'd0;
    nxt(); see("R6 ctx1 still stalled", 1'b0, 0, 0);
    cmp_vld = 1'b1; cmp_tid = 4'd1;
    nxt(); see("R5 ctx1 resumes", 1'b1, 1, 3);
    idle("R10 bubble", 17);
    nxt(); see("R6 spurious completion left ctx0 runnable", 1'b1, 0, 9);
  endtask

  task automatic t_spawn();
    reset_dut();
    launch(4);
    nxt(); see("R8 parent issues spawn", 1'b1, 0, 4);
    ins_op = 2'b01; launch(7);
    nxt(); see("R8 child inherits domain", 1'b1, 1, 4);
    nxt(); see("R9 launch got next free", 1'b1, 2, 7);
    idle("R10 bubble", 17);
    nxt(); see("R8 parent spacing", 1'b1, 0, 4);
    nxt(); see("R8 child spacing", 1'b1, 1, 4);
    nxt(); see("R9 launched spacing", 1'b1, 2, 7);
  endtask

  task automatic t_full();
    reset_dut();
    launch(0);
    for (int i = 1; i < NTHR; i++) begin
      nxt(); see("R2 fill contexts", 1'b1, i - 1, i - 1);
      launch(i);
    end
    nxt(); see("R2 last context", 1'b1, NTHR - 1, NTHR - 1);
    launch(12);
    idle("R12 launch when full ignored", 4);
    nxt(); see("R12 ctx0 unchanged", 1'b1, 0, 0);
    nxt(); see("R12 ctx1 unchanged", 1'b1, 1, 1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_rotate();
    t_lookahead();
    t_quit();
    t_spawn();
    t_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule